// File: doc/BRIEF.md
# Signal-fail defect clearance monitor

This block decides when a Signal Failure defect on a received SONET line may be withdrawn. A separate declare path signals when the defect is raised. From then on the block adds up the line parity (B2) errors that an upstream checker reports once per frame. It keeps this running total over a programmable observation window. The window length is counted in milliseconds, using a 1 ms tick supplied from outside. When a window completes, the total is compared with a programmable clear threshold. The defect is withdrawn only if the total is strictly below that threshold. Otherwise a fresh window begins with the total at zero.

The window length is 24 bits wide and is held in three byte registers. The clear threshold is 16 bits wide and is held in two byte registers. The host writes each byte through its own write strobe, and all five bytes can be read back. The line mode selects how many errors a single frame may contribute: at most 8 for a single-rate line with one parity byte, and at most 24 for a triple-rate line with three interleaved parity bytes. On the cycle the defect is withdrawn, a one-cycle clear pulse is raised for interrupt logic downstream.

Top module: `sf_clear_monitor`

## Requirements
- R1: After reset, `sf_active` and `sf_clear_pulse` are 0. All three window bytes read back as 0xFF. The threshold bytes read back as the `THR_RESET` value (default 0x0040).
- R2: Configuration byte index i is written from `cfg_wr_data` when `cfg_wr_en[i]` is 1, and reads back on `cfg_rd_data[8*i+7:8*i]` from the next cycle. The index map is: 0 = window bits 7:0, 1 = window bits 15:8, 2 = window bits 23:16, 3 = threshold bits 7:0, 4 = threshold bits 15:8.
- R3: A pulse on `sf_set` makes `sf_active` 1 in the next cycle. The same pulse restarts the window timer and sets the error total to zero, even if the defect was already active.
- R4: While the defect is active, a window of N ms ends on the N-th cycle in which `ms_tick` is 1 after the restart. The defect can only clear on that tick.
- R5: When a window ends, the defect clears in the next cycle if the error total (including any errors reported in the ending cycle) is strictly less than the threshold.
- R6: If the total is at or above the threshold when a window ends, `sf_active` stays 1 and a new window starts with the total at zero.
- R7: When `line_sts3` = 0, one frame adds at most 8 errors to the total. When `line_sts3` = 1, one frame adds at most 24 errors.
- R8: The 16-bit error total saturates at 0xFFFF and does not wrap.
- R9: A programmed window length of 0 behaves as a 1 ms window.
- R10: While `sf_active` is 0, error reports and ticks have no effect; the window timer and the error total stay idle.
- R11: If `sf_set` arrives in the same cycle as a window end, the set takes priority: no clear occurs and a new window starts.
- R12: `sf_clear_pulse` is 1 for exactly one cycle, namely the first cycle in which `sf_active` is 0 after a clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 5 | One write strobe per configuration byte |
| cfg_wr_data | input | 8 | Byte written to the selected configuration register |
| cfg_rd_data | output | 40 | All configuration bytes, index i at bits 8i+7:8i |
| line_sts3 | input | 1 | 1 = triple-rate line (at most 24 errors per frame), 0 = single-rate line (at most 8) |
| ms_tick | input | 1 | One-cycle pulse every millisecond |
| sf_set | input | 1 | Defect-raised event from the declare path |
| err_valid | input | 1 | Per-frame error count is valid |
| err_count | input | 5 | Parity errors in the frame |
| sf_active | output | 1 | Signal Failure defect is active |
| sf_clear_pulse | output | 1 | One-cycle pulse when the defect clears |

## Verification
The hardest state to reach from the ports is saturation of the error total. The bench reaches it with a single 1 ms window, a threshold of 0xFFFF, and 2731 consecutive frames of 24 errors each, which is 65544 errors in total. A wrapping total would fall to a small value and clear the defect; a saturating total holds it. The other hard case is a set arriving in the very cycle a window ends. The bench drives `sf_set` and `ms_tick` together on a 1 ms window, so that the set and the window end coincide.

// File: rtl/sf_clr_pkg.sv
package sf_clr_pkg;
  localparam int unsigned CFG_BYTE_W = 8;

  // Most errors one frame can report per line rate (parity bits in play)
  localparam int unsigned MAX_ERR_SINGLE = 8;
  localparam int unsigned MAX_ERR_TRIPLE = 24;

  typedef enum logic {
    RATE_SINGLE = 1'b0,
    RATE_TRIPLE = 1'b1
  } line_rate_e;
endpackage

// File: rtl/sf_clr_cfg.sv
module sf_clr_cfg
  import sf_clr_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 3,
  parameter int unsigned THR_BYTES = 2,
  parameter logic [THR_BYTES*CFG_BYTE_W-1:0] THR_RESET = 'h40,
  localparam int unsigned NBYTES = WIN_BYTES + THR_BYTES
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NBYTES-1:0]            wr_en,
  input  logic [CFG_BYTE_W-1:0]        wr_data,
  output logic [NBYTES*CFG_BYTE_W-1:0] cfg_flat
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    localparam logic [CFG_BYTE_W-1:0] RST_VAL =
      (g < WIN_BYTES) ? {CFG_BYTE_W{1'b1}}
                      : THR_RESET[(g - WIN_BYTES)*CFG_BYTE_W +: CFG_BYTE_W];
    logic [CFG_BYTE_W-1:0] byte_q;
    logic [CFG_BYTE_W-1:0] byte_d;

    always_comb begin
      byte_d = byte_q;
      if (wr_en[g]) byte_d = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) byte_q <= RST_VAL;
      else        byte_q <= byte_d;
    end

    assign cfg_flat[g*CFG_BYTE_W +: CFG_BYTE_W] = byte_q;
  end

endmodule

// File: rtl/sf_clr_win_timer.sv
module sf_clr_win_timer #(
  parameter int unsigned WIN_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             run,
  input  logic             tick,
  input  logic [WIN_W-1:0] win_len,
  output logic             win_end
);

  logic [WIN_W-1:0] cnt_q;
  logic [WIN_W-1:0] cnt_d;
  logic [WIN_W-1:0] len_eff;
  logic [WIN_W:0]   cnt_inc;

  always_comb begin
    len_eff = (win_len == '0) ? WIN_W'(1) : win_len;
    cnt_inc = {1'b0, cnt_q} + (WIN_W+1)'(1);
    win_end = run && tick && (cnt_inc >= {1'b0, len_eff});
  end

  always_comb begin
    cnt_d = cnt_q;
    if (restart)          cnt_d = '0;
    else if (run && tick) cnt_d = cnt_inc[WIN_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

endmodule

// File: rtl/sf_clr_err_accum.sv
module sf_clr_err_accum
  import sf_clr_pkg::*;
#(
  parameter int unsigned ERR_IN_W = 5,
  parameter int unsigned ACC_W    = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                restart,
  input  logic                run,
  input  line_rate_e          rate,
  input  logic                err_valid,
  input  logic [ERR_IN_W-1:0] err_count,
  output logic [ACC_W-1:0]    acc_upto
);

  localparam logic [ERR_IN_W-1:0] LIM_SINGLE = ERR_IN_W'(MAX_ERR_SINGLE);
  localparam logic [ERR_IN_W-1:0] LIM_TRIPLE = ERR_IN_W'(MAX_ERR_TRIPLE);

  logic [ACC_W-1:0]    acc_q;
  logic [ACC_W-1:0]    acc_d;
  logic [ERR_IN_W-1:0] lim;
  logic [ERR_IN_W-1:0] inc;
  logic [ACC_W:0]      sum;

  always_comb begin
    lim = (rate == RATE_TRIPLE) ? LIM_TRIPLE : LIM_SINGLE;
    inc = (err_count > lim) ? lim : err_count;
    sum = {1'b0, acc_q} + (ACC_W+1)'(inc);
    acc_upto = acc_q;
    if (run && err_valid) acc_upto = sum[ACC_W] ? {ACC_W{1'b1}} : sum[ACC_W-1:0];
  end

  always_comb begin
    acc_d = acc_q;
    if (restart)  acc_d = '0;
    else if (run) acc_d = acc_upto;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) acc_q <= '0;
    else        acc_q <= acc_d;
  end

endmodule

// File: rtl/sf_clr_state.sv
module sf_clr_state (
  input  logic clk,
  input  logic rst_n,
  input  logic sf_set,
  input  logic win_end,
  input  logic below_thr,
  output logic sf_q,
  output logic clr_pulse_q
);

  logic sf_d;
  logic clr_pulse_d;
  logic clear_now;

  always_comb begin
    clear_now   = sf_q && !sf_set && win_end && below_thr;
    clr_pulse_d = clear_now;
    sf_d        = sf_q;
    if (sf_set)         sf_d = 1'b1;
    else if (clear_now) sf_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sf_q        <= 1'b0;
      clr_pulse_q <= 1'b0;
    end else begin
      sf_q        <= sf_d;
      clr_pulse_q <= clr_pulse_d;
    end
  end

endmodule

// File: rtl/sf_clear_monitor.sv
module sf_clear_monitor
  import sf_clr_pkg::*;
#(
  parameter int unsigned WIN_BYTES = 3,
  parameter int unsigned THR_BYTES = 2,
  parameter int unsigned ERR_IN_W  = 5,
  parameter int unsigned ACC_W     = 16,
  parameter logic [THR_BYTES*CFG_BYTE_W-1:0] THR_RESET = 'h40,
  localparam int unsigned WIN_W     = WIN_BYTES * CFG_BYTE_W,
  localparam int unsigned THR_W     = THR_BYTES * CFG_BYTE_W,
  localparam int unsigned CFG_BYTES = WIN_BYTES + THR_BYTES
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic [CFG_BYTES-1:0]            cfg_wr_en,
  input  logic [CFG_BYTE_W-1:0]           cfg_wr_data,
  output logic [CFG_BYTES*CFG_BYTE_W-1:0] cfg_rd_data,
  input  logic                            line_sts3,
  input  logic                            ms_tick,
  input  logic                            sf_set,
  input  logic                            err_valid,
  input  logic [ERR_IN_W-1:0]             err_count,
  output logic                            sf_active,
  output logic                            sf_clear_pulse
);

  logic [CFG_BYTES*CFG_BYTE_W-1:0] cfg_flat;
  logic [WIN_W-1:0] win_len;
  logic [THR_W-1:0] thr;
  logic [ACC_W-1:0] acc_upto;
  logic             run;
  logic             restart;
  logic             win_end;
  logic             below_thr;
  logic             sf_q;
  line_rate_e       rate;

  sf_clr_cfg #(
    .WIN_BYTES(WIN_BYTES), .THR_BYTES(THR_BYTES), .THR_RESET(THR_RESET)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr_en), .wr_data(cfg_wr_data),
    .cfg_flat(cfg_flat)
  );

  always_comb begin
    win_len   = cfg_flat[WIN_W-1:0];
    thr       = cfg_flat[WIN_W +: THR_W];
    rate      = line_sts3 ? RATE_TRIPLE : RATE_SINGLE;
    run       = sf_q && !sf_set;
    restart   = sf_set || win_end;
    below_thr = acc_upto < ACC_W'(thr);
  end

  sf_clr_win_timer #(.WIN_W(WIN_W)) u_timer (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run),
    .tick(ms_tick), .win_len(win_len), .win_end(win_end)
  );

  sf_clr_err_accum #(.ERR_IN_W(ERR_IN_W), .ACC_W(ACC_W)) u_accum (
    .clk(clk), .rst_n(rst_n), .restart(restart), .run(run), .rate(rate),
    .err_valid(err_valid), .err_count(err_count), .acc_upto(acc_upto)
  );

  sf_clr_state u_state (
    .clk(clk), .rst_n(rst_n), .sf_set(sf_set), .win_end(win_end),
    .below_thr(below_thr), .sf_q(sf_q), .clr_pulse_q(sf_clear_pulse)
  );

  assign sf_active   = sf_q;
  assign cfg_rd_data = cfg_flat;

endmodule

// File: rtl/sf_clear_monitor_chk.sv
module sf_clear_monitor_chk #(
  parameter int unsigned CFG_BYTES = 5,
  parameter int unsigned BYTE_W    = 8
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic [CFG_BYTES-1:0]        cfg_wr_en,
  input logic [BYTE_W-1:0]           cfg_wr_data,
  input logic [CFG_BYTES*BYTE_W-1:0] cfg_rd_data,
  input logic                        ms_tick,
  input logic                        sf_set,
  input logic                        sf_active,
  input logic                        sf_clear_pulse
);

  // R3: a declare event always leaves the defect active
  p_set_active_r3: assert property (@(posedge clk) disable iff (!rst_n)
    sf_set |=> sf_active);

  // R4: the defect only falls on a millisecond tick
  p_fall_on_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sf_active) |-> $past(ms_tick));

  // R10: with no set, an idle monitor stays idle
  p_idle_holds_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (!sf_active && !sf_set) |=> !sf_active);

  // R11: a set blocks any clear in the same cycle
  p_set_wins_r11: assert property (@(posedge clk) disable iff (!rst_n)
    sf_set |=> !sf_clear_pulse);

  // R12: pulse marks the falling edge and lasts one cycle
  p_pulse_on_fall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sf_clear_pulse |-> $fell(sf_active));
  p_fall_has_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sf_active) |-> sf_clear_pulse);
  p_pulse_single_r12: assert property (@(posedge clk) disable iff (!rst_n)
    sf_clear_pulse |=> !sf_clear_pulse);

  // R2: each written byte reads back one cycle later
  for (genvar g = 0; g < CFG_BYTES; g++) begin : g_wr
    p_cfg_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      cfg_wr_en[g] |=> (cfg_rd_data[g*BYTE_W +: BYTE_W] == $past(cfg_wr_data)));
  end

endmodule

bind sf_clear_monitor sf_clear_monitor_chk #(
  .CFG_BYTES(CFG_BYTES), .BYTE_W(8)
) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
  .cfg_rd_data(cfg_rd_data), .ms_tick(ms_tick), .sf_set(sf_set),
  .sf_active(sf_active), .sf_clear_pulse(sf_clear_pulse)
);

// File: tb/sf_clear_monitor_tb.sv
module sf_clear_monitor_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NB = 5;

  logic          clk;
  logic          rst_n;
  logic [NB-1:0] cfg_wr_en;
  logic [7:0]    cfg_wr_data;
  logic [NB*8-1:0] cfg_rd_data;
  logic          line_sts3;
  logic          ms_tick;
  logic          sf_set;
  logic          err_valid;
  logic [4:0]    err_count;
  logic          sf_active;
  logic          sf_clear_pulse;

  int n_checks = 0;
  int n_err    = 0;
  bit done     = 0;

  sf_clear_monitor u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_wr_data(cfg_wr_data),
    .cfg_rd_data(cfg_rd_data), .line_sts3(line_sts3), .ms_tick(ms_tick),
    .sf_set(sf_set), .err_valid(err_valid), .err_count(err_count),
    .sf_active(sf_active), .sf_clear_pulse(sf_clear_pulse)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic wr(input int idx, input logic [7:0] val);
    cfg_wr_en = NB'(1) << idx; cfg_wr_data = val;
    step();
    cfg_wr_en = '0;
  endtask

  task automatic set_win(input logic [23:0] v);
    wr(0, v[7:0]); wr(1, v[15:8]); wr(2, v[23:16]);
  endtask

  task automatic set_thr(input logic [15:0] v);
    wr(3, v[7:0]); wr(4, v[15:8]);
  endtask

  task automatic raise_sf();
    sf_set = 1'b1; step(); sf_set = 1'b0;
  endtask

  task automatic tick();
    ms_tick = 1'b1; step(); ms_tick = 1'b0;
  endtask

  task automatic frame(input logic [4:0] n);
    err_valid = 1'b1; err_count = n; step(); err_valid = 1'b0;
  endtask

  // Last tick of a window must clear: sf low with pulse, then pulse gone
  task automatic expect_clear(input string req);
    tick();
    check(req, sf_active, 0);
    check({req, " R12 pulse"}, sf_clear_pulse, 1);
    step();
    check({req, " R12 pulse width"}, sf_clear_pulse, 0);
  endtask

  task automatic t_reset_r1();
    check("R1 sf_active", sf_active, 0);
    check("R1 pulse", sf_clear_pulse, 0);
    check("R1 window bytes", cfg_rd_data[23:0], 24'hFFFFFF);
    check("R1 threshold", cfg_rd_data[39:24], 16'h0040);
  endtask

  task automatic t_cfg_r2();
    set_win(24'h123456);
    set_thr(16'hA5C3);
    check("R2 window", cfg_rd_data[23:0], 24'h123456);
    check("R2 threshold", cfg_rd_data[39:24], 16'hA5C3);
  endtask

  task automatic t_window_r4_r5();
    set_win(3); set_thr(5); line_sts3 = 1'b1;
    raise_sf();
    check("R3 set", sf_active, 1);
    frame(4);
    tick(); check("R4 after 1 tick", sf_active, 1);
    tick(); check("R4 after 2 ticks", sf_active, 1);
    expect_clear("R5 below threshold clears");
  endtask

  task automatic t_at_thr_r6();
    set_win(2); set_thr(5);
    raise_sf();
    frame(5);
    tick(); tick();
    check("R6 count equal to threshold holds", sf_active, 1);
    check("R6 no pulse", sf_clear_pulse, 0);
    tick();
    expect_clear("R6 fresh window clears");
  endtask

  task automatic t_restart_r3();
    set_win(1); set_thr(5);
    raise_sf();
    frame(24);
    raise_sf();
    expect_clear("R3 re-set zeroes total");
  endtask

  task automatic t_clamp_r7();
    set_win(1); set_thr(9); line_sts3 = 1'b0;
    raise_sf(); frame(20);
    expect_clear("R7 single-rate clamp to 8");
    set_thr(25); line_sts3 = 1'b1;
    raise_sf(); frame(30);
    expect_clear("R7 triple-rate clamp to 24");
    set_thr(24);
    raise_sf(); frame(30);
    tick();
    check("R7 triple-rate 24 not below 24", sf_active, 1);
    expect_clear("R7 follow-up window");
  endtask

  task automatic t_saturate_r8();
    set_win(1); set_thr(16'hFFFF); line_sts3 = 1'b1;
    raise_sf();
    err_valid = 1'b1; err_count = 5'd24;
    for (int i = 0; i < 2731; i++) step();
    err_valid = 1'b0;
    tick();
    check("R8 saturated total holds defect", sf_active, 1);
    expect_clear("R8 next window clears");
  endtask

  task automatic t_zero_win_r9();
    set_win(0); set_thr(5);
    raise_sf();
    expect_clear("R9 zero window is 1 ms");
  endtask

  task automatic t_idle_r10();
    set_win(2); set_thr(5); line_sts3 = 1'b1;
    for (int i = 0; i < 10; i++) begin frame(24); tick(); end
    check("R10 stays inactive", sf_active, 0);
    raise_sf();
    tick();
    check("R10 timer was idle", sf_active, 1);
    expect_clear("R10 idle errors ignored");
  endtask

  task automatic t_set_priority_r11();
    set_win(1); set_thr(5);
    raise_sf();
    sf_set = 1'b1; ms_tick = 1'b1; step(); sf_set = 1'b0; ms_tick = 1'b0;
    check("R11 set wins over window end", sf_active, 1);
    check("R11 no pulse", sf_clear_pulse, 0);
    expect_clear("R11 next window clears");
  endtask

  initial begin
    rst_n = 1'b0; cfg_wr_en = '0; cfg_wr_data = '0; line_sts3 = 1'b0;
    ms_tick = 1'b0; sf_set = 1'b0; err_valid = 1'b0; err_count = '0;
    repeat (3) step();
    rst_n = 1'b1;
    step();
    t_reset_r1();
    t_cfg_r2();
    t_window_r4_r5();
    t_at_thr_r6();
    t_restart_r3();
    t_clamp_r7();
    t_saturate_r8();
    t_zero_win_r9();
    t_idle_r10();
    t_set_priority_r11();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end

endmodule